// File: doc/BRIEF.md
# Selectable-Rate Periodic Interrupt Generator

This block raises a periodic interrupt flag at one of several power-of-two rates. The rates come from a free-running binary prescaler that counts a 32.768 kHz tick enable. A 3-bit rate code in an 8-bit control register picks which prescaler tap produces the period events. A flag bit in the same register records that a period has elapsed, and it stays set until the host writes a 0 to it.

A half-rate mode covers 128, 32 and 8 Hz. With rate codes 1 to 3 it skips every other period event. The interrupt output follows the flag while a nonzero rate code is selected. The calendar and alarm logic are outside this block.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset, `ctl_rdata` reads 8'h00 and `irq_o` is 0.
- R2: `ctl_rdata` returns the flag in bit 7, the rate code in bits 6:4, the half-rate enable in bit 0, and zeros in bits 3:1. A write with `ctl_we` high loads the rate code from `ctl_wdata[6:4]` and the half-rate enable from `ctl_wdata[0]`.
- R3: The prescaler counts modulo 2^15 and advances only in cycles where `tick_i` is 1. It starts from 0 at reset.
- R4: A period event happens on a tick that brings the prescaler count to a multiple of the period. The period in ticks is 128, 512, 2048, 8192, 16384 or 32768 for rate codes 1 to 6, which gives 256, 64, 16, 4, 2 and 1 Hz. The flag reads 1 starting in the cycle after the clock edge that takes that tick.
- R5: Rate codes 0 and 7 never set the flag.
- R6: Writing 0 to bit 7 clears the flag. Writing 1 to bit 7 leaves the flag unchanged.
- R7: If a period event and a clearing write happen in the same cycle, the flag ends up set.
- R8: With the half-rate enable at 1 and rate code 1, 2 or 3, a toggle bit flips on every period event. Only events that find the toggle at 1 set the flag, which gives 128, 32 and 8 Hz.
- R9: For rate codes 4 to 6 the half-rate enable has no effect.
- R10: A write that changes the rate code clears the toggle. In half-rate mode, the first period event after the change is therefore skipped.
- R11: `irq_o` is 1 exactly when the flag is 1 and the rate code is nonzero. A pending flag stays readable while the rate code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 32.768 kHz tick enable, one cycle wide |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| irq_o | output | 1 | Periodic interrupt request |

## Verification
Every result is due one clock edge after its cause. A tick that completes a period shows in the flag and in `irq_o` in the cycle after the edge that takes it. A write shows in the read value after its edge. A clearing write that meets a period event resolves at that same edge. The bench drives inputs at the falling edge and updates its own model at the rising edge. It then compares the read value and `irq_o` at the next falling edge, one edge after the stimulus, in every cycle. The bench also places a clearing write exactly on the cycle of a period event, and it changes the rate code in half-rate mode to check the toggle reset.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int unsigned CODE_W = 3;
  localparam int unsigned NCODE  = 6;

  // prescaler bits that must all be ones for a given rate code (0 = no tap)
  function automatic int unsigned tap_bits(input int unsigned code, input int unsigned div_w);
    int unsigned r;
    if (code >= 1 && code <= 4) r = div_w - 10 + 2 * code;
    else if (code == 5 || code == 6) r = div_w - 6 + code;
    else r = 0;
    return r;
  endfunction

  function automatic logic half_capable(input logic [CODE_W-1:0] code);
    return (code >= 3'd1) && (code <= 3'd3);
  endfunction
endpackage

// File: rtl/pir_prescaler.sv
module pir_prescaler #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [6:1]       tap_o
);
  import pir_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_i) cnt_o <= cnt_o + 1'b1;
  end

  for (genvar c = 1; c <= 6; c++) begin : g_tap
    localparam int unsigned TB = tap_bits(c, DIV_W);
    localparam logic [DIV_W-1:0] MASK = {DIV_W{1'b1}} >> (DIV_W - TB);
    assign tap_o[c] = tick_i && ((cnt_o & MASK) == MASK);
  end

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pir_tap_sel.sv
module pir_tap_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:1] tap_i,
  input  logic [2:0] code_i,
  input  logic       half_i,
  input  logic       code_chg_i,
  output logic       period_evt_o,
  output logic       set_evt_o,
  output logic       tog_o
);
  import pir_pkg::*;
  logic half_act;

  always_comb begin
    case (code_i)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: period_evt_o = tap_i[code_i];
      default: period_evt_o = 1'b0;
    endcase
  end

  assign half_act  = half_i && half_capable(code_i);
  assign set_evt_o = period_evt_o && (!half_act || tog_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        tog_o <= 1'b0;
    else if (code_chg_i)               tog_o <= 1'b0;
    else if (period_evt_o && half_act) tog_o <= ~tog_o;
  end

  // R8
  half_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_act && period_evt_o && !tog_o) |-> !set_evt_o);
  // R5
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 3'd0 || code_i == 3'd7) |-> !set_evt_o);
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen #(
  parameter int unsigned DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       irq_o
);
  import pir_pkg::*;

  logic [DIV_W-1:0]  cnt;
  logic [6:1]        taps;
  logic [CODE_W-1:0] code_q;
  logic              half_q, flag_q;
  logic              code_chg, period_evt, set_evt, tog;

  assign code_chg = ctl_we && (ctl_wdata[6:4] != code_q);

  pir_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cnt_o(cnt), .tap_o(taps)
  );

  pir_tap_sel u_sel (
    .clk(clk), .rst_n(rst_n), .tap_i(taps), .code_i(code_q), .half_i(half_q),
    .code_chg_i(code_chg), .period_evt_o(period_evt), .set_evt_o(set_evt),
    .tog_o(tog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      half_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        code_q <= ctl_wdata[6:4];
        half_q <= ctl_wdata[0];
      end
      // a period event wins over a clearing write
      if (set_evt)     flag_q <= 1'b1;
      else if (ctl_we) flag_q <= flag_q & ctl_wdata[7];
    end
  end

  assign ctl_rdata = {flag_q, code_q, 3'b000, half_q};
  assign irq_o     = flag_q && (code_q != '0);

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[7] && !set_evt) |=> !flag_q);
  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));
  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctl_rdata[7]);
endmodule

// File: tb/periodic_irq_gen_tb_top.sv
module periodic_irq_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int total = 0;
  int bad = 0;
  string cur_req = "R1";

  // bench model
  int unsigned m_cnt = 0;
  logic [2:0]  m_code = 0;
  logic        m_half = 0, m_flag = 0, m_tog = 0;

  always #10 clk = ~clk;   // 50 MHz

  periodic_irq_gen dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ctl_we(we),
    .ctl_wdata(wdata), .ctl_rdata(rdata), .irq_o(irq)
  );

  function automatic int unsigned period_of(input logic [2:0] c);
    case (c)
      3'd1: return 128;
      3'd2: return 512;
      3'd3: return 2048;
      3'd4: return 8192;
      3'd5: return 16384;
      3'd6: return 32768;
      default: return 0;
    endcase
  endfunction

  function automatic logic model_event(input int unsigned cnt, input logic t, input logic [2:0] c);
    int unsigned p = period_of(c);
    if (!t || p == 0) return 1'b0;
    return ((cnt + 1) % p) == 0;
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      logic ev, hact, setv;
      ev   = model_event(m_cnt, tick, m_code);
      hact = m_half && (m_code >= 1) && (m_code <= 3);
      setv = ev && (!hact || m_tog);
      if (we && wdata[6:4] != m_code) m_tog = 1'b0;
      else if (ev && hact)            m_tog = ~m_tog;
      if (setv)    m_flag = 1'b1;
      else if (we) m_flag = m_flag & wdata[7];
      if (we) begin m_code = wdata[6:4]; m_half = wdata[0]; end
      if (tick) m_cnt = (m_cnt + 1) % 32768;
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // one cycle: compare at the falling edge, then drive new inputs
  task automatic cyc(input logic w, input logic [7:0] d, input logic t);
    @(negedge clk);
    check({cur_req, " rdata"}, rdata, {m_flag, m_code, 3'b000, m_half});
    check({cur_req, " R11 irq"}, {7'd0, irq}, {7'd0, m_flag && (m_code != 0)});
    we = w; wdata = d; tick = t;
  endtask

  // run cycles with occasional random clearing writes and tick gaps
  task automatic run(input int n, input logic [2:0] c, input logic h, input logic gaps);
    for (int i = 0; i < n; i++) begin
      logic t = gaps ? (($urandom % 4) != 0) : 1'b1;
      if (($urandom % 97) == 0)
        cyc(1'b1, {($urandom % 2 == 0) ? 1'b1 : 1'b0, c, 3'b000, h}, t);
      else
        cyc(1'b0, 8'h00, t);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic h, input logic f);
    cyc(1'b1, {f, c, 3'b000, h}, 1'b1);
  endtask

  initial begin
    #3800000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    cur_req = "R1"; cyc(1'b0, 8'h00, 1'b0);
    // R2: field layout, bits 3:1 written as ones read back zero
    cur_req = "R2"; cyc(1'b1, 8'h7f, 1'b0); cyc(1'b0, 8'h00, 1'b0);
    cur_req = "R5"; wr(3'd0, 1'b0, 1'b0); run(300, 3'd0, 1'b0, 1'b0);
    wr(3'd7, 1'b0, 1'b0); run(300, 3'd7, 1'b0, 1'b0);
    // R3 and R4: each rate, some with tick gaps
    cur_req = "R4"; wr(3'd1, 1'b0, 1'b0); run(500, 3'd1, 1'b0, 1'b0);
    cur_req = "R3"; run(700, 3'd1, 1'b0, 1'b1);
    cur_req = "R4"; wr(3'd2, 1'b0, 1'b0); run(1700, 3'd2, 1'b0, 1'b0);
    wr(3'd3, 1'b0, 1'b0); run(5000, 3'd3, 1'b0, 1'b0);
    wr(3'd4, 1'b0, 1'b0); run(9000, 3'd4, 1'b0, 1'b0);
    wr(3'd5, 1'b0, 1'b0); run(17000, 3'd5, 1'b0, 1'b0);
    wr(3'd6, 1'b0, 1'b0); run(33500, 3'd6, 1'b0, 1'b0);
    // R11: pending flag survives a switch to code 0 but irq drops
    cur_req = "R11"; wr(3'd0, 1'b0, 1'b1); run(20, 3'd0, 1'b0, 1'b0);
    // R6: write 1 keeps, write 0 clears
    cur_req = "R6"; wr(3'd1, 1'b0, 1'b1); run(300, 3'd1, 1'b0, 1'b0);
    wr(3'd1, 1'b0, 1'b1); cyc(1'b0, 8'h00, 1'b0);
    wr(3'd1, 1'b0, 1'b0); cyc(1'b0, 8'h00, 1'b0);
    // R7: clear write exactly on a period event
    cur_req = "R7";
    while ((m_cnt % 128) != 126) cyc(1'b0, 8'h00, 1'b1);
    wr(3'd1, 1'b0, 1'b0);
    cyc(1'b0, 8'h00, 1'b1);
    check("R7 flag after collision", {7'd0, rdata[7]}, 8'h01);
    // R8: half rate on codes 1..3
    cur_req = "R8";
    for (int c = 1; c <= 3; c++) begin
      wr(c[2:0], 1'b1, 1'b0);
      run(period_of(c[2:0]) * 5, c[2:0], 1'b1, 1'b0);
    end
    // R10: code change clears the toggle
    cur_req = "R10"; wr(3'd1, 1'b1, 1'b0); run(200, 3'd1, 1'b1, 1'b0);
    wr(3'd2, 1'b1, 1'b0); run(1200, 3'd2, 1'b1, 1'b0);
    // R9: half enable ignored on code 4
    cur_req = "R9"; wr(3'd4, 1'b1, 1'b0); run(17000, 3'd4, 1'b1, 1'b0);
    cyc(1'b0, 8'h00, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule